// File: doc/BRIEF.md
# PLL Lock Detector with Acquisition Restart

This block watches the correction pulses of a phase-frequency detector and declares lock once those pulses have stayed narrow for a programmable run of consecutive reference periods. The up and down pulse lines arrive already sampled into the system clock domain. A one-clock reference strobe marks the last system clock of each reference period. In every period the block counts how many system clocks each pulse line was high and treats the longer of the two totals as the width of that period. A period is narrow when this width is below a threshold picked by one select bit. A saturating run counter counts consecutive narrow periods, and the lock flag rises when the run reaches a target picked by a two-bit select.

Any wide period ends the run and drops the flag at once. A strobe that starts a new acquisition does the same, and it also discards the period in progress. Software would issue that strobe whenever it writes a new loop frequency. The enable bit gates the whole detector: while it is low, the flag stays low and nothing is counted.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `lock_flag` is 0 and the run count is zero, so a full run of narrow periods is needed before lock.
- R2: While `det_en` is 0, `lock_flag` is 0 from the next clock edge on and no periods are counted. Lowering `det_en` after lock clears the flag.
- R3: A period's width is the larger of two totals: the number of clocks `pd_up` was high and the number of clocks `pd_dn` was high. Each total counts every clock since the previous strobe, including the clock that carries `ref_tick`, and adds up separate bursts.
- R4: With `thr_sel`=0 a period is narrow when its width is below 4 clocks. With `thr_sel`=1 it is narrow when its width is below 8 clocks.
- R5: `tgt_sel` values 0, 1, 2 and 3 set the lock target to 64, 256, 1024 and 4096 consecutive narrow periods. `lock_flag` rises at the clock edge that samples the `ref_tick` ending the target-th narrow period, and at no other time.
- R6: A period that is not narrow sets the run count to zero and clears `lock_flag` at the edge that samples its `ref_tick`.
- R7: `acq_restart` clears `lock_flag` and the run count at the next edge. It also discards the period in progress, and it takes priority over a `ref_tick` in the same clock.
- R8: Once set, `lock_flag` stays 1 as long as each later period is narrow and neither `acq_restart` nor a low `det_en` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detector enable |
| thr_sel | input | 1 | Width threshold select (0: 4 clocks, 1: 8 clocks) |
| tgt_sel | input | 2 | Lock target select (64, 256, 1024, 4096 periods) |
| pd_up | input | 1 | Sampled up correction pulse |
| pd_dn | input | 1 | Sampled down correction pulse |
| ref_tick | input | 1 | Marks the final clock of a reference period |
| acq_restart | input | 1 | One-clock strobe that starts a new acquisition |
| lock_flag | output | 1 | Lock-detect flag |

## Verification
The bench drives runs that end exactly at the target and one period short of it, for each of the four targets. A counter that is off by one would lock early or late. Widths that sit exactly at the threshold show whether the comparison is strict, and pulses split into bursts or ending on the strobe clock show whether the width total is complete. Other cases put the long pulse on the down line only, place a restart in the same clock as a strobe, and drop the enable. A design that took only the up pulse, let the strobe win over the restart, or left a partial run standing across a restart would leave the flag high or raise it early.

// File: rtl/ld_pkg.sv
package ld_pkg;

  // Width threshold in system clocks for a given select bit.
  function automatic int ld_width_limit(input logic sel, input int lo, input int hi);
    return sel ? hi : lo;
  endfunction

  // Consecutive narrow periods needed for lock: base times four per select step.
  function automatic int ld_count_target(input logic [1:0] sel, input int base);
    return base << (2 * int'(sel));
  endfunction

  function automatic int ld_max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ld_width_meter.sv
module ld_width_meter #(
  parameter int WID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             pd_up,
  input  logic             pd_dn,
  input  logic             ref_tick,
  output logic [WID_W-1:0] cyc_width
);

  localparam logic [WID_W-1:0] WID_SAT = {WID_W{1'b1}};

  logic             pulse [2];
  logic [WID_W-1:0] ch_total [2];

  assign pulse[0] = pd_up;
  assign pulse[1] = pd_dn;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [WID_W-1:0] acc_q;
    logic [WID_W-1:0] acc_inc;

    // Saturating total of high clocks, including the current clock.
    assign acc_inc      = (acc_q == WID_SAT) ? acc_q : acc_q + 1'b1;
    assign ch_total[ch] = pulse[ch] ? acc_inc : acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 acc_q <= '0;
      else if (clear || ref_tick) acc_q <= '0;
      else                        acc_q <= ch_total[ch];
    end

    AST_METER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      ref_tick |=> (acc_q == '0)); // R3
  end

  assign cyc_width = (ch_total[0] > ch_total[1]) ? ch_total[0] : ch_total[1];

endmodule

// File: rtl/ld_run_counter.sv
module ld_run_counter #(
  parameter int CNT_W   = 13,
  parameter int CNT_SAT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cyc_done,
  input  logic             cyc_narrow,
  output logic [CNT_W-1:0] run_count,
  output logic [CNT_W-1:0] run_count_d
);

  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(CNT_SAT);

  always_comb begin
    run_count_d = run_count;
    if (clear)
      run_count_d = '0;
    else if (cyc_done) begin
      if (!cyc_narrow)             run_count_d = '0;
      else if (run_count != SAT_V) run_count_d = run_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_count <= '0;
    else        run_count <= run_count_d;
  end

  AST_WIDE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !cyc_narrow) |=> (run_count == '0)); // R6

  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (run_count == '0)); // R7

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && cyc_narrow && !clear && run_count < SAT_V)
      |=> (run_count == $past(run_count) + 1'b1)); // R5

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_count <= SAT_V); // R5

endmodule

// File: rtl/ld_lock_flag.sv
module ld_lock_flag #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cyc_done,
  input  logic             cyc_narrow,
  input  logic [CNT_W-1:0] run_count_d,
  input  logic [CNT_W-1:0] target,
  output logic             lock_flag
);

  logic flag_d;

  always_comb begin
    flag_d = lock_flag;
    if (clear)         flag_d = 1'b0;
    else if (cyc_done) flag_d = cyc_narrow && (run_count_d >= target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_flag <= 1'b0;
    else        lock_flag <= flag_d;
  end

  AST_RISE_ON_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flag) |-> $past(cyc_done && cyc_narrow)); // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_flag && !clear && !cyc_done) |=> lock_flag); // R8

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int THR_LO    = 4,
  parameter int THR_HI    = 8,
  parameter int TGT_BASE  = 64,
  parameter int TGT_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 det_en,
  input  logic                 thr_sel,
  input  logic [TGT_SEL_W-1:0] tgt_sel,
  input  logic                 pd_up,
  input  logic                 pd_dn,
  input  logic                 ref_tick,
  input  logic                 acq_restart,
  output logic                 lock_flag
);
  import ld_pkg::*;

  localparam int TGT_MAX = TGT_BASE << (2 * ((1 << TGT_SEL_W) - 1));
  localparam int CNT_W   = $clog2(TGT_MAX + 1);
  localparam int THR_MAX = (THR_HI > THR_LO) ? THR_HI : THR_LO;
  localparam int WID_W   = $clog2(THR_MAX + 1);

  // Named internal events.
  logic             meter_clear;
  logic             cyc_done;
  logic             cyc_narrow;
  logic [WID_W-1:0] cyc_width;
  logic [WID_W-1:0] width_limit;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] run_count;
  logic [CNT_W-1:0] run_count_d;

  assign meter_clear = !det_en || acq_restart;
  assign cyc_done    = ref_tick && !meter_clear;
  assign width_limit = WID_W'(ld_width_limit(thr_sel, THR_LO, THR_HI));
  assign target      = CNT_W'(ld_count_target(2'(tgt_sel), TGT_BASE));
  assign cyc_narrow  = cyc_width < width_limit;

  ld_width_meter #(.WID_W(WID_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (meter_clear),
    .pd_up     (pd_up),
    .pd_dn     (pd_dn),
    .ref_tick  (ref_tick),
    .cyc_width (cyc_width)
  );

  ld_run_counter #(.CNT_W(CNT_W), .CNT_SAT(TGT_MAX)) u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (meter_clear),
    .cyc_done    (cyc_done),
    .cyc_narrow  (cyc_narrow),
    .run_count   (run_count),
    .run_count_d (run_count_d)
  );

  ld_lock_flag #(.CNT_W(CNT_W)) u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (meter_clear),
    .cyc_done    (cyc_done),
    .cyc_narrow  (cyc_narrow),
    .run_count_d (run_count_d),
    .target      (target),
    .lock_flag   (lock_flag)
  );

  AST_ACQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    acq_restart |=> !lock_flag); // R7

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !lock_flag); // R2

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flag) |-> $past(ref_tick && det_en && !acq_restart)); // R5

  AST_WIDE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !cyc_narrow) |=> !lock_flag); // R6

endmodule

// File: tb/pll_lock_detect_test.sv
`timescale 1ns/1ps
module pll_lock_detect_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       det_en = 1'b0;
  logic       thr_sel = 1'b0;
  logic [1:0] tgt_sel = 2'd0;
  logic       pd_up = 1'b0;
  logic       pd_dn = 1'b0;
  logic       ref_tick = 1'b0;
  logic       acq_restart = 1'b0;
  logic       lock_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pll_lock_detect uut (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .thr_sel(thr_sel),
    .tgt_sel(tgt_sel), .pd_up(pd_up), .pd_dn(pd_dn), .ref_tick(ref_tick),
    .acq_restart(acq_restart), .lock_flag(lock_flag)
  );

  // Bench's own restatement of the configuration tables.
  function automatic int exp_limit(input logic s);
    return s ? 8 : 4;
  endfunction
  function automatic int exp_target(input logic [1:0] s);
    case (s)
      2'd0: return 64;
      2'd1: return 256;
      2'd2: return 1024;
      default: return 4096;
    endcase
  endfunction

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // One reference period: masks give which clocks each pulse is high; tick on last.
  task automatic run_pattern(input logic [15:0] um, input logic [15:0] dm, input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      pd_up    = um[k];
      pd_dn    = dm[k];
      ref_tick = (k == len - 1);
    end
  endtask

  task automatic run_cycle(input int up_w, input int dn_w);
    int len;
    len = ((up_w > dn_w) ? up_w : dn_w) + 2;
    run_pattern(16'((32'd1 << up_w) - 1), 16'((32'd1 << dn_w) - 1), len);
  endtask

  task automatic run_n(input int up_w, input int dn_w, input int n);
    for (int i = 0; i < n; i++) run_cycle(up_w, dn_w);
  endtask

  task automatic settle;
    @(negedge clk);
    pd_up = 1'b0; pd_dn = 1'b0; ref_tick = 1'b0; acq_restart = 1'b0;
  endtask

  task automatic restart;
    @(negedge clk);
    pd_up = 1'b0; pd_dn = 1'b0; ref_tick = 1'b0; acq_restart = 1'b1;
    @(negedge clk);
    acq_restart = 1'b0;
  endtask

  // {thr_sel[23], tgt_sel[22:21], up[20:17], dn[16:13], periods[12:0]}
  localparam logic [23:0] VEC [10] = '{
    {1'b0, 2'd0, 4'd3, 4'd0, 13'd64},
    {1'b0, 2'd0, 4'd3, 4'd2, 13'd63},
    {1'b0, 2'd0, 4'd4, 4'd0, 13'd64},
    {1'b1, 2'd0, 4'd7, 4'd7, 13'd64},
    {1'b1, 2'd0, 4'd0, 4'd8, 13'd64},
    {1'b0, 2'd0, 4'd0, 4'd5, 13'd64},
    {1'b0, 2'd1, 4'd1, 4'd1, 13'd256},
    {1'b0, 2'd1, 4'd1, 4'd1, 13'd255},
    {1'b0, 2'd2, 4'd2, 4'd3, 13'd1024},
    {1'b1, 2'd3, 4'd5, 4'd0, 13'd4096}
  };

  initial begin
    #700000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lock_flag, 1'b0, "R1", "flag in reset");
    rst_n = 1'b1;
    settle();
    check(lock_flag, 1'b0, "R1", "flag after reset");
    det_en = 1'b1;
    // R1: run count starts at zero, so 63 narrow periods are not enough.
    run_n(0, 0, 63); settle();
    check(lock_flag, 1'b0, "R1", "63 periods from reset");
    run_n(0, 0, 1); settle();
    check(lock_flag, 1'b1, "R5", "64th period from reset");

    // Table walk: R3 R4 R5 over thresholds, targets, and up or down dominance.
    for (int v = 0; v < 10; v++) begin
      logic exp;
      int up_w, dn_w, n;
      thr_sel = VEC[v][23];
      tgt_sel = VEC[v][22:21];
      up_w    = int'(VEC[v][20:17]);
      dn_w    = int'(VEC[v][16:13]);
      n       = int'(VEC[v][12:0]);
      restart();
      run_n(up_w, dn_w, n); settle();
      exp = (((up_w > dn_w) ? up_w : dn_w) < exp_limit(thr_sel)) && (n >= exp_target(tgt_sel));
      check(lock_flag, exp, "R4/R5", $sformatf("vector %0d", v));
    end

    // R8: flag persists over further narrow periods.
    thr_sel = 1'b0; tgt_sel = 2'd0;
    restart(); run_n(3, 3, 64); run_n(1, 2, 100); settle();
    check(lock_flag, 1'b1, "R8", "held over narrow periods");

    // R6: one wide period drops the flag and restarts the run.
    run_n(0, 4, 1); settle();
    check(lock_flag, 1'b0, "R6", "wide period clears");
    run_n(0, 0, 63); settle();
    check(lock_flag, 1'b0, "R6", "63 after wide");
    run_n(0, 0, 1); settle();
    check(lock_flag, 1'b1, "R6", "64 after wide");

    // R3: split bursts sum; 2+2 = 4 clocks is wide at threshold 4.
    run_pattern(16'b0011_0011, 16'h0, 8); settle();
    check(lock_flag, 1'b0, "R3", "split bursts total 4");
    restart(); run_n(0, 0, 64);
    run_pattern(16'b0010_1001, 16'h0, 8); settle();
    check(lock_flag, 1'b1, "R3", "split bursts total 3");
    // R3: the strobe clock itself counts (clocks 2..5 of 6, tick on 5).
    run_pattern(16'b11_1100, 16'h0, 6); settle();
    check(lock_flag, 1'b0, "R3", "pulse ending on strobe clock");

    // R7: restart after lock clears at once.
    restart(); run_n(0, 0, 64); settle();
    check(lock_flag, 1'b1, "R7", "locked before restart");
    @(negedge clk); acq_restart = 1'b1;
    @(negedge clk); acq_restart = 1'b0;
    check(lock_flag, 1'b0, "R7", "flag one edge after restart");
    // R7: partial run discarded by restart.
    run_n(0, 0, 40); restart(); run_n(0, 0, 40); settle();
    check(lock_flag, 1'b0, "R7", "partial run discarded");
    run_n(0, 0, 24); settle();
    check(lock_flag, 1'b1, "R7", "full run after restart");
    // R7: restart in the same clock as the strobe of the 64th period wins.
    restart(); run_n(0, 0, 63);
    @(negedge clk); ref_tick = 1'b1; acq_restart = 1'b1;
    settle();
    check(lock_flag, 1'b0, "R7", "restart beats strobe");
    run_n(0, 0, 63); settle();
    check(lock_flag, 1'b0, "R7", "63 after collided restart");
    run_n(0, 0, 1); settle();
    check(lock_flag, 1'b1, "R7", "64 after collided restart");

    // R2: disable clears flag and blocks counting.
    @(negedge clk); det_en = 1'b0;
    @(negedge clk);
    check(lock_flag, 1'b0, "R2", "flag drops when disabled");
    run_n(0, 0, 64); settle();
    check(lock_flag, 1'b0, "R2", "no lock while disabled");
    det_en = 1'b1;
    run_n(0, 0, 63); settle();
    check(lock_flag, 1'b0, "R2", "63 after enable");
    run_n(0, 0, 1); settle();
    check(lock_flag, 1'b1, "R2", "64 after enable");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule